// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-mapped station manager that runs one Clause-22 management transaction at a time on a two-wire MDC/MDIO bus to an external PHY. Software first writes the PHY address and the register number into an address register. For a write, it also loads a 16-bit data word. It then starts the transaction by setting either a read-request bit or a write-request bit in a control register. It polls a busy flag until that flag drops, and for a read it collects the result from a read-data register.

The serial side derives MDC from the system clock with a parameterised half-period divider. MDIO changes only on falling MDC edges and is sampled on rising edges. During the turnaround and data phase of a read, the controller releases the line so that the PHY can drive it. A frame always carries the full 32-bit preamble of ones.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the status, address, write-data and read-data registers read 0, MDC is low and the MDIO output enable is low.
- R2: Register word 0 holds the PHY address in bits 12:8 and the register number in bits 4:0, and reads back with all other bits 0. Word 1 holds the 16-bit write data.
- R3: A write to the control register (word 2) with bit 3 set and bit 2 clear starts a read. A write with bit 2 set and bit 3 clear starts a write. From the next cycle, bit 0 of the status register (word 3) reads 1.
- R4: A control write with both request bits set, or with neither set, starts nothing, and the status stays 0.
- R5: The request bits self-clear, so the control register always reads 0. A request written while busy is ignored: the running frame continues unchanged and no second frame follows.
- R6: MDC is low while idle. During a transaction it has a period of 2*HALF_DIV system cycles and first rises HALF_DIV cycles after acceptance.
- R7: A write frame sends, MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 data bits. MDIO changes only at acceptance or on a falling MDC edge.
- R8: A read frame sends 32 ones, 01, opcode 10, the PHY address and the register number. The output enable is then low for the last 18 bit times (turnaround and data).
- R9: During a read, MDIO input is sampled on the rising MDC edges of the last 16 bit times, MSB first, into the low 16 bits of the read-data register (word 4). A write transaction leaves the read-data register unchanged.
- R10: The busy flag clears, with the output enable low and MDC low, exactly 128*HALF_DIV cycles after acceptance. This is far inside a 10 ms polling limit for any practical divider.
- R11: Writes to the address or write-data register during a transaction update the registers but do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 addr, 1 wdata, 2 control, 3 status, 4 rdata) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low releases the line) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with HALF_DIV set to 3. This odd half-period exercises the divider terminal count away from powers of two. It also keeps a full 64-bit frame to 384 cycles, so several reads and writes fit in one run, including all-ones address fields and read patterns with set MSB and LSB. A behavioural model predicts MDC, the enable and every driven bit each cycle. It also acts as the PHY, returning data in the read data phase.

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl #(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [4:0]  phy_q, regn_q;
  logic [15:0] wdat_q, rdat_q;
  logic        busy_q, is_rd_q, mdc_q, oe_q;
  logic [63:0] shf_q;
  logic [5:0]  bit_q;
  logic [CW-1:0] cnt_q;

  wire ctrl_wr = reg_we && (reg_addr == 3'd2);
  wire start   = ctrl_wr && (reg_wdata[3] ^ reg_wdata[2]) && !busy_q;
  wire tick    = busy_q && (cnt_q == TERM);
  wire rise    = tick && !mdc_q;
  wire fall    = tick && mdc_q;
  wire last    = (bit_q == 6'd63);

  assign mdc     = mdc_q;
  assign mdio_oe = oe_q;
  assign mdio_o  = oe_q & shf_q[63];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q <= '0; regn_q <= '0; wdat_q <= '0; rdat_q <= '0;
      busy_q <= 1'b0; is_rd_q <= 1'b0; mdc_q <= 1'b0; oe_q <= 1'b0;
      shf_q <= '0; bit_q <= '0; cnt_q <= '0;
    end else begin
      if (reg_we && reg_addr == 3'd0) begin
        phy_q  <= reg_wdata[12:8];
        regn_q <= reg_wdata[4:0];
      end
      if (reg_we && reg_addr == 3'd1) wdat_q <= reg_wdata;
      if (start) begin
        busy_q  <= 1'b1;
        is_rd_q <= reg_wdata[3];
        cnt_q   <= '0;
        mdc_q   <= 1'b0;
        bit_q   <= '0;
        oe_q    <= 1'b1;
        shf_q   <= {32'hFFFF_FFFF, 2'b01, reg_wdata[3] ? 2'b10 : 2'b01, phy_q, regn_q,
                    reg_wdata[3] ? 18'h0 : {2'b10, wdat_q}};
      end else if (busy_q) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (rise) begin
          mdc_q <= 1'b1;
          if (is_rd_q && bit_q >= 6'd48) rdat_q <= {rdat_q[14:0], mdio_i};
        end
        if (fall) begin
          mdc_q <= 1'b0;
          if (last) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            shf_q <= {shf_q[62:0], 1'b0};
            oe_q  <= !is_rd_q || (bit_q < 6'd45);
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {3'b000, phy_q, 3'b000, regn_q};
      3'd1:    reg_rdata = wdat_q;
      3'd3:    reg_rdata = {15'h0, busy_q};
      3'd4:    reg_rdata = rdat_q;
      default: reg_rdata = 16'h0;
    endcase
  end

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(reg_we && reg_addr == 3'd2 && (reg_wdata[3] != reg_wdata[2])));
  // R4
  dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && reg_we && reg_addr == 3'd2 && reg_wdata[3] && reg_wdata[2]) |=> !busy_q);
  // R7
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !$rose(busy_q) && !$fell(mdc_q)) |-> $stable(mdio_o));
  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_rd_q && bit_q >= 6'd46) |-> !mdio_oe);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdio_oe && !mdc));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd3;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int compared = 0, mismatched = 0;
  int t = -1;
  logic exp_rd = 1'b0;
  logic [63:0] fr = '0;
  logic [4:0] m_phy = '0, m_reg = '0;
  logic [15:0] m_wd = '0, m_rdat = '0, phy_val = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl #(.HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (t >= 0 && exp_rd && (t / (2*H)) >= 48) ? phy_val[63 - (t / (2*H))] : 1'b1;

  function automatic logic [63:0] mk(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, rd ? 18'h0 : {2'b10, d}};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      t = -1; m_phy = '0; m_reg = '0; m_wd = '0; m_rdat = '0;
    end else begin
      automatic bit was = (t >= 0);
      if (was) begin
        t++;
        if (t == 128*H) begin
          if (exp_rd) m_rdat = phy_val;
          t = -1;
        end
      end
      if (!was && reg_we && reg_addr == 3'd2 && (reg_wdata[3] != reg_wdata[2])) begin
        exp_rd = reg_wdata[3];
        fr = mk(reg_wdata[3], m_phy, m_reg, m_wd);
        t = 0;
      end
      if (reg_we && reg_addr == 3'd0) begin m_phy = reg_wdata[12:8]; m_reg = reg_wdata[4:0]; end
      if (reg_we && reg_addr == 3'd1) m_wd = reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic emdc = 1'b0, eoe = 1'b0;
      automatic int k = 0;
      if (t >= 0) begin
        k = t / (2*H);
        emdc = ((t / H) % 2) == 1;
        eoe = !exp_rd || (k < 46);
      end
      chk("R6 mdc", {15'h0, mdc}, {15'h0, emdc});
      chk("R8/R10 mdio_oe", {15'h0, mdio_oe}, {15'h0, eoe});
      if (eoe) chk("R7/R8 mdio_o", {15'h0, mdio_o}, {15'h0, fr[63 - k]});
    end
  end

  task automatic rd(logic [2:0] a, logic [15:0] e, string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, e);
    reg_addr = 3'd3; #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd3; #1;
  endtask

  task automatic wait_idle(output int n);
    n = 0; reg_addr = 3'd3; #1;
    while (reg_rdata[0] === 1'b1 && n < 100000) begin
      @(negedge clk); #1; n++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; #1;
    rd(3, 16'h0, "R1 status");
    rd(0, 16'h0, "R1 addr");
    rd(4, 16'h0, "R1 rdata");
    chk("R1 mdc/oe", {14'h0, mdc, mdio_oe}, 16'h0);

    wr(0, 16'hFFFF); rd(0, 16'h1F1F, "R2 addr mask");
    wr(0, 16'h150A); rd(0, 16'h150A, "R2 addr");
    wr(1, 16'hA5C3); rd(1, 16'hA5C3, "R2 wdata");

    wr(2, 16'h000C); rd(3, 16'h0, "R4 both bits");
    wr(2, 16'h0000); rd(3, 16'h0, "R4 no bits");
    wr(2, 16'hFFF3); rd(3, 16'h0, "R4 other bits");

    wr(2, 16'h0004); rd(3, 16'h1, "R3 write busy");
    rd(2, 16'h0, "R5 self-clear");
    wr(0, 16'h0707);
    wr(1, 16'h0F0F);
    wr(2, 16'h0008); rd(3, 16'h1, "R5 still busy");
    wait_idle(n);
    rd(0, 16'h0707, "R11 addr updated");
    rd(4, 16'h0, "R9 write leaves rdata");
    repeat (10) @(negedge clk); #1;
    rd(3, 16'h0, "R5 no queued request");

    phy_val = 16'hBEEF;
    wr(0, 16'h0301);
    wr(2, 16'h0008);
    wait_idle(n);
    chk("R10 duration", 16'(n), 16'(128*H));
    rd(4, 16'hBEEF, "R9 read data");

    wr(1, 16'h1234);
    wr(2, 16'h0004);
    wait_idle(n);
    rd(4, 16'hBEEF, "R9 rdata kept");

    phy_val = 16'h8001;
    wr(0, 16'h1F1F);
    wr(2, 16'h0008);
    wait_idle(n);
    rd(4, 16'h8001, "R9 read edges");
    chk("R10 model idle", 16'(t < 0), 16'h1);

    repeat (8) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule